// File: doc/BRIEF.md
# Interrupt Controller Command Port Decoder

This block is the byte-wide, two-address register front end of an eight-line programmable interrupt controller. Software writes bytes to an even or an odd address. The block sorts each write into one of three kinds. It can be the first word of an initialization sequence, an operation command, or a register load. From that it keeps the vector base, the mode bits and the interrupt mask. It also sends single-cycle command strobes, each with a line argument, to the priority resolver core. The resolver core is a separate block.

A write to the even address with bit 4 set restarts initialization. Up to three more words then arrive at the odd address. When no initialization is in progress, odd-address writes load the mask. Reads at the even address return the request or in-service vector supplied by the core. In poll mode they return the winning line instead and acknowledge it. All outputs are registered and change on the clock edge that samples the strobe.

Top module: `pic_cmd_port`

## Requirements
- R1: After a synchronous reset, the following are all zero: mask, vector base, every mode flag, the readback select, poll mode, every strobe and the read data.
- R2: An even-address write with bit 4 set has these effects one cycle later. It pulses `init_clr` for one cycle. It clears the mask, vector base, mode flags, readback select and poll mode. It records in bit 0 whether a fourth word will follow.
- R3: The first odd-address write after that word sets `vec_base` to the written byte with bits 2:0 forced to 0.
- R4: The next odd-address write is consumed with no visible effect. When a fourth word was requested, the odd write after it sets `sfnm_mode` from bit 4 and `auto_eoi_mode` from bit 1. When it was not requested, that write loads the mask instead.
- R5: With no initialization in progress, an odd-address write loads `mask_reg`. An odd-address read returns the mask.
- R6: An even-address write with bit 4 = 0 and bit 3 = 1 is a read-control word. If bit 1 = 1, `rd_svc_sel` takes bit 0. If bit 6 = 1, `spec_mask_mode` takes bit 5. Bit 2 = 1 enters poll mode. Fields with their enable at 0 keep their value.
- R7: An even-address read outside poll mode returns `svc_vec` when `rd_svc_sel` = 1 and `req_vec` otherwise.
- R8: An even-address write with bits 4:3 = 00 is a priority command decoded from bits 7:5, with `cmd_line` set from bits 2:0. The codes are:
  - 001: non-specific EOI.
  - 011: specific EOI.
  - 101: rotating non-specific EOI.
  - 111: rotating specific EOI.
  - 110: set priority, which pulses `prio_stb` instead of `eoi_stb`.
  - 010: no effect.
- R9: Priority command codes 000 and 100 set `rot_aeoi_mode` from bit 7 and pulse no strobe.
- R10: In poll mode, an even-address read while `win_valid` = 1 returns 0x80 OR the winning line. It pulses `poll_ack` with `poll_line` equal to that line, and it leaves poll mode.
- R11: In poll mode, an even-address read while `win_valid` = 0 returns 0x00, pulses no `poll_ack`, and leaves poll mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 1 | Register address bit (0 even, 1 odd) |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| req_vec | input | 8 | Pending request vector from the core |
| svc_vec | input | 8 | In-service vector from the core |
| win_valid | input | 1 | Core has an unmasked winning line |
| win_line | input | 3 | Winning line number from the core |
| rdata | output | 8 | Registered read data |
| vec_base | output | 8 | Vector base, low three bits zero |
| sfnm_mode | output | 1 | Special fully nested mode |
| auto_eoi_mode | output | 1 | Automatic EOI mode |
| rot_aeoi_mode | output | 1 | Rotate on automatic EOI |
| spec_mask_mode | output | 1 | Special mask mode |
| mask_reg | output | 8 | Interrupt mask |
| rd_svc_sel | output | 1 | Even read returns in-service (1) or request (0) |
| poll_mode | output | 1 | Next even read is a poll |
| init_clr | output | 1 | Pulse: core clears request, in-service and rotation base |
| eoi_stb | output | 1 | Pulse: end-of-interrupt command |
| eoi_specific | output | 1 | EOI names `cmd_line` |
| eoi_rotate | output | 1 | EOI also rotates priority |
| prio_stb | output | 1 | Pulse: set lowest priority to `cmd_line` |
| cmd_line | output | 3 | Line argument of the command |
| poll_ack | output | 1 | Pulse: core clears request and in-service of `poll_line` |
| poll_line | output | 3 | Line acknowledged by a poll |

## Verification
The bench runs initialization twice: once with the fourth word requested and once without. This shows whether a word-counting error shifts an odd write into the mask or out of it. Read-control words are sent with each enable bit both set and clear. This separates a field that is written only when enabled from one that follows its data bit every time. Every priority-command code is written, including the no-operation code and both rotate-on-auto-EOI codes. Each strobe combination and line argument is then compared. Poll reads are issued with a winner present and with none, which separates the acknowledge path from the empty response.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;

    localparam int DW = 8;
    localparam int LW = 3;

    typedef enum logic [1:0] {
        INIT_IDLE  = 2'd0,
        INIT_BASE  = 2'd1,
        INIT_CASC  = 2'd2,
        INIT_EXTRA = 2'd3
    } init_st_t;

    typedef enum logic [1:0] {
        WK_NONE  = 2'd0,
        WK_START = 2'd1,
        WK_RDCTL = 2'd2,
        WK_PRIO  = 2'd3
    } wkind_t;

    typedef struct packed {
        logic          eoi;
        logic          spec;
        logic          rot;
        logic          setprio;
        logic          raeoi_wr;
        logic [LW-1:0] line;
    } prio_cmd_t;

    function automatic wkind_t classify(input logic a, input logic [DW-1:0] d);
        if (a)         return WK_NONE;
        else if (d[4]) return WK_START;
        else if (d[3]) return WK_RDCTL;
        else           return WK_PRIO;
    endfunction

    function automatic prio_cmd_t decode_prio(input logic [DW-1:0] d);
        prio_cmd_t c;
        c = '0;
        c.line = d[LW-1:0];
        case (d[7:5])
            3'b001: c.eoi = 1'b1;
            3'b011: begin c.eoi = 1'b1; c.spec = 1'b1; end
            3'b101: begin c.eoi = 1'b1; c.rot = 1'b1; end
            3'b111: begin c.eoi = 1'b1; c.spec = 1'b1; c.rot = 1'b1; end
            3'b110: c.setprio = 1'b1;
            3'b000, 3'b100: c.raeoi_wr = 1'b1;
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pic_init_seq.sv
module pic_init_seq
    import pic_cmd_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          odd_wr,
    input  logic [DW-1:0] wdata,
    output logic          idle,
    output logic          init_clr,
    output logic [DW-1:0] vec_base,
    output logic          sfnm_mode,
    output logic          auto_eoi_mode
);
    localparam logic [DW-1:0] BASE_MASK = ~((DW)'(1 << LW) - (DW)'(1));

    init_st_t st;
    logic     want_extra;

    assign idle = (st == INIT_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st            <= INIT_IDLE;
            want_extra    <= 1'b0;
            init_clr      <= 1'b0;
            vec_base      <= '0;
            sfnm_mode     <= 1'b0;
            auto_eoi_mode <= 1'b0;
        end else begin
            init_clr <= start;
            if (start) begin
                st            <= INIT_BASE;
                want_extra    <= wdata[0];
                vec_base      <= '0;
                sfnm_mode     <= 1'b0;
                auto_eoi_mode <= 1'b0;
            end else if (odd_wr) begin
                case (st)
                    INIT_BASE: begin
                        vec_base <= wdata & BASE_MASK;
                        st       <= INIT_CASC;
                    end
                    INIT_CASC:  st <= want_extra ? INIT_EXTRA : INIT_IDLE;
                    INIT_EXTRA: begin
                        sfnm_mode     <= wdata[4];
                        auto_eoi_mode <= wdata[1];
                        st            <= INIT_IDLE;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/pic_op_decode.sv
module pic_op_decode
    import pic_cmd_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  wkind_t        kind,
    input  logic          wr_en,
    input  logic          mask_wr,
    input  logic          poll_done,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] mask_reg,
    output logic          rd_svc_sel,
    output logic          poll_mode,
    output logic          spec_mask_mode,
    output logic          rot_aeoi_mode,
    output logic          eoi_stb,
    output logic          eoi_specific,
    output logic          eoi_rotate,
    output logic          prio_stb,
    output logic [LW-1:0] cmd_line
);
    prio_cmd_t pc;
    logic      is_start, is_rdctl, is_prio;

    always_comb begin
        pc       = decode_prio(wdata);
        is_start = wr_en && (kind == WK_START);
        is_rdctl = wr_en && (kind == WK_RDCTL);
        is_prio  = wr_en && (kind == WK_PRIO);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_reg       <= '0;
            rd_svc_sel     <= 1'b0;
            poll_mode      <= 1'b0;
            spec_mask_mode <= 1'b0;
            rot_aeoi_mode  <= 1'b0;
            eoi_stb        <= 1'b0;
            eoi_specific   <= 1'b0;
            eoi_rotate     <= 1'b0;
            prio_stb       <= 1'b0;
            cmd_line       <= '0;
        end else begin
            eoi_stb  <= is_prio && pc.eoi;
            prio_stb <= is_prio && pc.setprio;
            if (is_prio) begin
                eoi_specific <= pc.spec;
                eoi_rotate   <= pc.rot;
                cmd_line     <= pc.line;
            end
            if (poll_done) poll_mode <= 1'b0;
            if (is_start) begin
                mask_reg       <= '0;
                rd_svc_sel     <= 1'b0;
                poll_mode      <= 1'b0;
                spec_mask_mode <= 1'b0;
                rot_aeoi_mode  <= 1'b0;
            end else begin
                if (mask_wr) mask_reg <= wdata;
                if (is_rdctl) begin
                    if (wdata[1]) rd_svc_sel     <= wdata[0];
                    if (wdata[6]) spec_mask_mode <= wdata[5];
                    if (wdata[2]) poll_mode      <= 1'b1;
                end
                if (is_prio && pc.raeoi_wr) rot_aeoi_mode <= wdata[7];
            end
        end
    end
endmodule

// File: rtl/pic_read_port.sv
module pic_read_port
    import pic_cmd_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic          addr,
    input  logic          poll_mode,
    input  logic          rd_svc_sel,
    input  logic [DW-1:0] mask_reg,
    input  logic [DW-1:0] req_vec,
    input  logic [DW-1:0] svc_vec,
    input  logic          win_valid,
    input  logic [LW-1:0] win_line,
    output logic          poll_done,
    output logic [DW-1:0] rdata,
    output logic          poll_ack,
    output logic [LW-1:0] poll_line
);
    localparam int PADW = DW - LW - 1;

    assign poll_done = rd_en && !addr && poll_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata     <= '0;
            poll_ack  <= 1'b0;
            poll_line <= '0;
        end else begin
            poll_ack <= 1'b0;
            if (rd_en) begin
                if (addr) begin
                    rdata <= mask_reg;
                end else if (poll_mode) begin
                    if (win_valid) begin
                        rdata     <= {1'b1, {PADW{1'b0}}, win_line};
                        poll_ack  <= 1'b1;
                        poll_line <= win_line;
                    end else begin
                        rdata <= '0;
                    end
                end else begin
                    rdata <= rd_svc_sel ? svc_vec : req_vec;
                end
            end
        end
    end
endmodule

// File: rtl/pic_cmd_port.sv
module pic_cmd_port
    import pic_cmd_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          addr,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [7:0]    wdata,
    input  logic [7:0]    req_vec,
    input  logic [7:0]    svc_vec,
    input  logic          win_valid,
    input  logic [2:0]    win_line,
    output logic [7:0]    rdata,
    output logic [7:0]    vec_base,
    output logic          sfnm_mode,
    output logic          auto_eoi_mode,
    output logic          rot_aeoi_mode,
    output logic          spec_mask_mode,
    output logic [7:0]    mask_reg,
    output logic          rd_svc_sel,
    output logic          poll_mode,
    output logic          init_clr,
    output logic          eoi_stb,
    output logic          eoi_specific,
    output logic          eoi_rotate,
    output logic          prio_stb,
    output logic [2:0]    cmd_line,
    output logic          poll_ack,
    output logic [2:0]    poll_line
);
    wkind_t kind;
    logic   start, odd_wr, init_idle, mask_wr, poll_done;

    assign kind    = classify(addr, wdata);
    assign start   = wr_en && (kind == WK_START);
    assign odd_wr  = wr_en && addr;
    assign mask_wr = odd_wr && init_idle;

    pic_init_seq u_init (
        .clk(clk), .rst(rst), .start(start), .odd_wr(odd_wr), .wdata(wdata),
        .idle(init_idle), .init_clr(init_clr), .vec_base(vec_base),
        .sfnm_mode(sfnm_mode), .auto_eoi_mode(auto_eoi_mode)
    );

    pic_op_decode u_op (
        .clk(clk), .rst(rst), .kind(kind), .wr_en(wr_en), .mask_wr(mask_wr),
        .poll_done(poll_done), .wdata(wdata), .mask_reg(mask_reg),
        .rd_svc_sel(rd_svc_sel), .poll_mode(poll_mode),
        .spec_mask_mode(spec_mask_mode), .rot_aeoi_mode(rot_aeoi_mode),
        .eoi_stb(eoi_stb), .eoi_specific(eoi_specific), .eoi_rotate(eoi_rotate),
        .prio_stb(prio_stb), .cmd_line(cmd_line)
    );

    pic_read_port u_rd (
        .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .poll_mode(poll_mode),
        .rd_svc_sel(rd_svc_sel), .mask_reg(mask_reg), .req_vec(req_vec),
        .svc_vec(svc_vec), .win_valid(win_valid), .win_line(win_line),
        .poll_done(poll_done), .rdata(rdata), .poll_ack(poll_ack),
        .poll_line(poll_line)
    );
endmodule

// File: rtl/pic_cmd_port_chk.sv
module pic_cmd_port_chk (
    input logic       clk,
    input logic       rst,
    input logic       addr,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] wdata,
    input logic       win_valid,
    input logic [2:0] win_line,
    input logic [7:0] rdata,
    input logic [7:0] vec_base,
    input logic [7:0] mask_reg,
    input logic       poll_mode,
    input logic       rot_aeoi_mode,
    input logic       init_clr,
    input logic       eoi_stb,
    input logic       prio_stb,
    input logic [2:0] cmd_line,
    input logic       poll_ack,
    input logic       init_idle
);
    a_r2_start_clears: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !addr && wdata[4]) |=> (init_clr && mask_reg == 8'h00 && vec_base == 8'h00 && !poll_mode));

    a_r5_mask_load: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr && init_idle) |=> (mask_reg == $past(wdata)));

    a_r8_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        $onehot0({eoi_stb, prio_stb, init_clr}));

    a_r8_setprio_line: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !addr && wdata[4:3] == 2'b00 && wdata[7:5] == 3'b110)
        |=> (prio_stb && !eoi_stb && cmd_line == $past(wdata[2:0])));

    a_r9_raeoi: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !addr && wdata[4:3] == 2'b00 && wdata[6:5] == 2'b00)
        |=> (rot_aeoi_mode == $past(wdata[7]) && !eoi_stb && !prio_stb));

    a_r10_poll_hit: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !addr && poll_mode && win_valid && !wr_en)
        |=> (poll_ack && rdata == {5'b10000, $past(win_line)} && !poll_mode));

    a_r11_poll_miss: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !addr && poll_mode && !win_valid && !wr_en)
        |=> (!poll_ack && rdata == 8'h00 && !poll_mode));
endmodule

bind pic_cmd_port pic_cmd_port_chk u_chk (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .win_valid(win_valid), .win_line(win_line), .rdata(rdata),
    .vec_base(vec_base), .mask_reg(mask_reg), .poll_mode(poll_mode),
    .rot_aeoi_mode(rot_aeoi_mode), .init_clr(init_clr), .eoi_stb(eoi_stb),
    .prio_stb(prio_stb), .cmd_line(cmd_line), .poll_ack(poll_ack),
    .init_idle(init_idle)
);

// File: tb/pic_cmd_port_tb.sv
module pic_cmd_port_tb;
    logic       clk = 1'b0, rst = 1'b1;
    logic       addr = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0, req_vec = '0, svc_vec = '0;
    logic       win_valid = 1'b0;
    logic [2:0] win_line = '0;
    logic [7:0] rdata, vec_base, mask_reg;
    logic       sfnm_mode, auto_eoi_mode, rot_aeoi_mode, spec_mask_mode;
    logic       rd_svc_sel, poll_mode, init_clr, eoi_stb, eoi_specific, eoi_rotate;
    logic       prio_stb, poll_ack;
    logic [2:0] cmd_line, poll_line;

    always #5 clk = ~clk;

    pic_cmd_port u_dut (.*);

    typedef enum int {F_RDATA, F_BASE, F_SFNM, F_AEOI, F_RAEOI, F_SMM, F_MASK,
                      F_RSEL, F_POLL, F_ICLR, F_EOI, F_ESPEC, F_EROT, F_PRIO,
                      F_LINE, F_PACK, F_PLINE} field_t;
    typedef struct { string tag; field_t f; logic [7:0] v; } exp_t;

    exp_t q[$];
    event chk_ev;
    int   checks = 0, errors = 0;
    bit   done = 0;

    function automatic logic [7:0] probe(field_t f);
        case (f)
            F_RDATA: return rdata;
            F_BASE:  return vec_base;
            F_SFNM:  return {7'd0, sfnm_mode};
            F_AEOI:  return {7'd0, auto_eoi_mode};
            F_RAEOI: return {7'd0, rot_aeoi_mode};
            F_SMM:   return {7'd0, spec_mask_mode};
            F_MASK:  return mask_reg;
            F_RSEL:  return {7'd0, rd_svc_sel};
            F_POLL:  return {7'd0, poll_mode};
            F_ICLR:  return {7'd0, init_clr};
            F_EOI:   return {7'd0, eoi_stb};
            F_ESPEC: return {7'd0, eoi_specific};
            F_EROT:  return {7'd0, eoi_rotate};
            F_PRIO:  return {7'd0, prio_stb};
            F_LINE:  return {5'd0, cmd_line};
            F_PACK:  return {7'd0, poll_ack};
            default: return {5'd0, poll_line};
        endcase
    endfunction

    // monitor: drains expected items at each check point
    initial begin
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                exp_t e;
                logic [7:0] a;
                e = q.pop_front();
                a = probe(e.f);
                checks++;
                if (a !== e.v) begin
                    errors++;
                    $display("FAIL %s field %s: actual %02h expected %02h", e.tag, e.f.name(), a, e.v);
                end
            end
        end
    end

    task automatic expect_f(string tag, field_t f, logic [7:0] v);
        exp_t e;
        e.tag = tag; e.f = f; e.v = v;
        q.push_back(e);
    endtask

    task automatic fire();
        -> chk_ev;
        #1;
    endtask

    task automatic wr(logic a, logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(logic a);
        @(negedge clk); addr = a; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic prio_chk(string tag, logic [7:0] d, logic e, logic s, logic r, logic p);
        wr(1'b0, d);
        expect_f(tag, F_EOI, {7'd0, e});
        expect_f(tag, F_PRIO, {7'd0, p});
        if (e) begin
            expect_f(tag, F_ESPEC, {7'd0, s});
            expect_f(tag, F_EROT, {7'd0, r});
        end
        if (e || p) expect_f(tag, F_LINE, {5'd0, d[2:0]});
        fire();
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        expect_f("R1", F_MASK, 8'h00); expect_f("R1", F_BASE, 8'h00);
        expect_f("R1", F_RDATA, 8'h00); expect_f("R1", F_POLL, 0);
        expect_f("R1", F_ICLR, 0); expect_f("R1", F_EOI, 0);
        expect_f("R1", F_SFNM, 0); expect_f("R1", F_PACK, 0);
        fire();

        // R2 start with fourth word requested
        wr(1'b0, 8'h11);
        expect_f("R2", F_ICLR, 1); expect_f("R2", F_MASK, 8'h00); fire();
        @(negedge clk); expect_f("R2", F_ICLR, 0); fire();
        // R3 base
        wr(1'b1, 8'h4D); expect_f("R3", F_BASE, 8'h48); fire();
        // R4 third word has no effect
        wr(1'b1, 8'hFF);
        expect_f("R4", F_MASK, 8'h00); expect_f("R4", F_BASE, 8'h48); fire();
        wr(1'b1, 8'h12);
        expect_f("R4", F_SFNM, 1); expect_f("R4", F_AEOI, 1); expect_f("R4", F_MASK, 8'h00); fire();
        // R5 mask load and readback
        wr(1'b1, 8'hA5); expect_f("R5", F_MASK, 8'hA5); fire();
        rd(1'b1); expect_f("R5", F_RDATA, 8'hA5); fire();

        // R7 request readback, R6 readback select
        req_vec = 8'h3C; svc_vec = 8'h81;
        rd(1'b0); expect_f("R7", F_RDATA, 8'h3C); fire();
        wr(1'b0, 8'h0B); expect_f("R6", F_RSEL, 1); fire();
        rd(1'b0); expect_f("R7", F_RDATA, 8'h81); fire();
        wr(1'b0, 8'h08); expect_f("R6", F_RSEL, 1); fire();
        wr(1'b0, 8'h68); expect_f("R6", F_SMM, 1); fire();
        wr(1'b0, 8'h28); expect_f("R6", F_SMM, 1); expect_f("R6", F_POLL, 0); fire();

        // R8 priority command codes
        prio_chk("R8", 8'h20, 1, 0, 0, 0);
        prio_chk("R8", 8'h63, 1, 1, 0, 0);
        prio_chk("R8", 8'hA0, 1, 0, 1, 0);
        prio_chk("R8", 8'hE5, 1, 1, 1, 0);
        prio_chk("R8", 8'hC6, 0, 0, 0, 1);
        prio_chk("R8", 8'h47, 0, 0, 0, 0);
        // R9 rotate on auto EOI
        prio_chk("R9", 8'h80, 0, 0, 0, 0);
        expect_f("R9", F_RAEOI, 1); fire();
        prio_chk("R9", 8'h00, 0, 0, 0, 0);
        expect_f("R9", F_RAEOI, 0); fire();

        // R10 poll with a winner
        wr(1'b0, 8'h0C); expect_f("R6", F_POLL, 1); fire();
        win_valid = 1'b1; win_line = 3'd5;
        rd(1'b0);
        expect_f("R10", F_RDATA, 8'h85); expect_f("R10", F_PACK, 1);
        expect_f("R10", F_PLINE, 8'h05); expect_f("R10", F_POLL, 0); fire();
        @(negedge clk); expect_f("R10", F_PACK, 0); fire();
        // R11 poll with nothing pending
        wr(1'b0, 8'h0C);
        win_valid = 1'b0;
        rd(1'b0);
        expect_f("R11", F_RDATA, 8'h00); expect_f("R11", F_PACK, 0);
        expect_f("R11", F_POLL, 0); fire();

        // R2 restart without fourth word, R4 path to mask
        wr(1'b0, 8'h10);
        expect_f("R2", F_ICLR, 1); expect_f("R2", F_MASK, 8'h00);
        expect_f("R2", F_RSEL, 0); expect_f("R2", F_SMM, 0);
        expect_f("R2", F_SFNM, 0); expect_f("R2", F_AEOI, 0); expect_f("R2", F_BASE, 8'h00);
        fire();
        wr(1'b1, 8'h0F); expect_f("R3", F_BASE, 8'h08); fire();
        wr(1'b1, 8'h00); expect_f("R4", F_MASK, 8'h00); fire();
        wr(1'b1, 8'h5A);
        expect_f("R4", F_MASK, 8'h5A); expect_f("R4", F_SFNM, 0); fire();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule